// File: doc/BRIEF.md
# Channel Equalization Training Sequencer

This block runs the equalization phase of display link training. It starts only after clock recovery has already succeeded. When started, it picks the richest training pattern that both ends of the link support and ties the scrambler setting to that choice. It then writes the pattern byte and the current drive setting of every active lane to the receiver through an abstract auxiliary-channel request port.

It then repeats a fixed loop: wait for the equalization delay through a timer handshake, read the receiver status, and decide. The phase ends with failure when any active lane has lost clock lock. It ends with success when every active lane reports equalization done and symbol lock and the lanes are aligned. Otherwise an external adjustment resolver turns the receiver's adjust requests into a new drive byte, and the block writes that byte to the lane registers.

The loop runs at most a fixed number of times. On every exit the transmitter pattern select returns to idle, and the block pulses a completion flag along with a pass/fail result. Two warning flags report a high link rate that lacks the pattern it would normally need. While the block is idle, a separate stop request writes a single pattern byte that disables training.

Top module: `eq_train_seq`

## Requirements
- R1: On `start_i`, the pattern is 4 if `src_p4_i` and `snk_p4_i` are both set, else 3 if `src_p3_i` and `snk_p3_i` are both set, else 2. The pattern code in bits [3:0] of the pattern byte is 7, 3 or 2 respectively. `tx_pat_o` shows 4, 3 or 2 while the phase runs.
- R2: Bit 5 of the pattern byte (scramble disable) is 1 for patterns 2 and 3 and 0 for pattern 4. All other bits of the pattern byte are 0.
- R3: The first transaction is an `aux_op_o`=1 write of length lanes+1. Byte 0 is the pattern byte, bytes 1..lanes hold `drive_init_i`, and all higher bytes are 0.
- R4: Each iteration completes a `wait_req_o`/`wait_done_i` handshake and then issues a status read (`aux_op_o`=0) of length LANES+1 bytes. The status layout is: lane i nibble at bits [4i+3:4i] (bit0 clock lock, bit1 equalized, bit2 symbol lock); alignment bit at bit 4*LANES; adjust bits at [8*LANES+7:4*LANES+8].
- R5: If the status read shows any active lane (index < lanes) without clock lock, the phase ends at once with failure and calls no adjustment. Inactive lanes are ignored.
- R6: The phase passes only when every active lane has both the equalized and symbol-lock bits set and the alignment bit is set.
- R7: Otherwise the adjust bits are presented on `adj_bits_o` with `adj_req_o`. The returned `adj_drive_i` is then written with `aux_op_o`=2 and length lanes: bytes 0..lanes-1 hold the drive, the rest are 0.
- R8: At most MAX_ITER (5) iterations run. After the lane write of the last iteration, the phase fails.
- R9: On every exit, `done_o` pulses for one cycle with `tx_pat_o`=0 (idle). `pass_o` gives the result and holds until the next start.
- R10: A transaction answered with `aux_ok_i`=0 ends the phase with failure.
- R11: `stop_i` in idle issues one `aux_op_o`=1 write of length 1 with byte 0 equal to 0x00, and does not pulse `done_o`.
- R12: `warn_p4_o` is set when the rate equals 810 (in 10 Mb/s units) and pattern 4 was not chosen. `warn_p3_o` is set when the rate is at least 540 and pattern 2 was chosen. Both are latched at start.
- R13: `aux_req_o`, `wait_req_o` and `adj_req_o` stay high with stable command until answered, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the equalization phase (idle only) |
| stop_i | input | 1 | Write the training-disable byte (idle only) |
| src_p4_i | input | 1 | Source supports pattern 4 |
| snk_p4_i | input | 1 | Sink supports pattern 4 |
| src_p3_i | input | 1 | Source supports pattern 3 |
| snk_p3_i | input | 1 | Sink supports pattern 3 |
| rate_i | input | RATE_W | Link rate in 10 Mb/s units |
| lanes_i | input | clog2(LANES+1) | Active lane count |
| drive_init_i | input | 8 | Drive byte left by clock recovery |
| aux_req_o | output | 1 | Auxiliary transaction request |
| aux_op_o | output | 2 | 0 status read, 1 write from pattern byte, 2 write from lane bytes |
| aux_len_o | output | clog2(LANES+2) | Transaction length in bytes |
| aux_wdata_o | output | 8*(LANES+1) | Write bytes, byte 0 in bits [7:0] |
| aux_ack_i | input | 1 | Transaction answered |
| aux_ok_i | input | 1 | Transaction succeeded (with ack) |
| aux_rdata_i | input | 8*LANES+8 | Status read data (with ack) |
| wait_req_o | output | 1 | Start equalization delay |
| wait_done_i | input | 1 | Delay elapsed |
| adj_req_o | output | 1 | Adjustment resolve request |
| adj_bits_o | output | 4*LANES | Receiver adjust bits |
| adj_done_i | input | 1 | Resolver answered |
| adj_drive_i | input | 8 | New drive byte |
| tx_pat_o | output | 3 | Transmitter pattern: 0 idle, 2, 3, 4 |
| warn_p4_o | output | 1 | Top rate without pattern 4 |
| warn_p3_o | output | 1 | High rate with only pattern 2 |
| done_o | output | 1 | Phase ended (one cycle) |
| pass_o | output | 1 | Phase result |

## Verification
The hardest case to reach is a run that spends every allowed iteration without converging. Only that run shows that the final lane write happens before the failure and that no sixth wait starts. The bench's auxiliary responder takes its status replies from a script indexed by read count. A script of five replies, each with lock held but no equalization, walks the sequencer to its bound. Other scripts produce a lock loss on the second read only, and a fault in the alignment bit or a single lane's symbol lock alone.

// File: rtl/eq_train_pkg.sv
package eq_train_pkg;

  typedef enum logic [2:0] {
    PAT_IDLE = 3'd0,
    PAT_2    = 3'd2,
    PAT_3    = 3'd3,
    PAT_4    = 3'd4
  } pat_e;

  typedef enum logic [1:0] {
    AUX_RD      = 2'd0,
    AUX_WR_PAT  = 2'd1,
    AUX_WR_LANE = 2'd2
  } aux_op_e;

  typedef enum logic [1:0] {
    FR_PAT_LANES = 2'd0,
    FR_LANES     = 2'd1,
    FR_PAT_ONLY  = 2'd2
  } frame_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_PAT, S_WAIT, S_RD, S_ADJ, S_WR_LANE, S_EXIT, S_STOP
  } state_e;

  localparam int SCR_OFF_BIT = 5;

  function automatic logic [3:0] pat_code(pat_e p);
    case (p)
      PAT_4:   return 4'h7;
      PAT_3:   return 4'h3;
      PAT_2:   return 4'h2;
      default: return 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/eq_pat_sel.sv
module eq_pat_sel
  import eq_train_pkg::*;
#(
  parameter int RATE_W  = 16,
  parameter int RATE_P4 = 810,
  parameter int RATE_P3 = 540
) (
  input  logic              src_p4_i,
  input  logic              snk_p4_i,
  input  logic              src_p3_i,
  input  logic              snk_p3_i,
  input  logic [RATE_W-1:0] rate_i,
  output pat_e              pat_o,
  output logic [7:0]        pat_byte_o,
  output logic              warn_p4_o,
  output logic              warn_p3_o
);

  always_comb begin
    if (src_p4_i && snk_p4_i)      pat_o = PAT_4;
    else if (src_p3_i && snk_p3_i) pat_o = PAT_3;
    else                           pat_o = PAT_2;
  end

  always_comb begin
    pat_byte_o              = '0;
    pat_byte_o[3:0]         = pat_code(pat_o);
    pat_byte_o[SCR_OFF_BIT] = (pat_o != PAT_4);
  end

  assign warn_p4_o = (rate_i == RATE_W'(RATE_P4)) && (pat_o != PAT_4);
  assign warn_p3_o = (rate_i >= RATE_W'(RATE_P3)) && (pat_o == PAT_2);

endmodule

// File: rtl/eq_lane_eval.sv
module eq_lane_eval #(
  parameter int LANES  = 4,
  parameter int LCNT_W = $clog2(LANES+1)
) (
  input  logic [LANES*4-1:0] sts_i,
  input  logic               align_i,
  input  logic [LCNT_W-1:0]  lanes_i,
  output logic               cr_ok_o,
  output logic               eq_ok_o
);

  logic [LANES-1:0] cr_v, eq_v, unused_hi;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic act;
    assign act          = (LCNT_W'(i) < lanes_i);
    assign cr_v[i]      = !act || sts_i[4*i];
    assign eq_v[i]      = !act || (sts_i[4*i+1] && sts_i[4*i+2]);
    assign unused_hi[i] = sts_i[4*i+3];
  end

  logic unused_bits;
  assign unused_bits = ^unused_hi;

  assign cr_ok_o = &cr_v;
  assign eq_ok_o = (&eq_v) && align_i;

endmodule

// File: rtl/eq_frame.sv
module eq_frame
  import eq_train_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LCNT_W = $clog2(LANES+1),
  parameter int LEN_W  = $clog2(LANES+2)
) (
  input  frame_e               mode_i,
  input  logic [7:0]           pat_byte_i,
  input  logic [7:0]           drive_i,
  input  logic [LCNT_W-1:0]    lanes_i,
  output logic [(LANES+1)*8-1:0] wdata_o,
  output logic [LEN_W-1:0]     len_o
);

  for (genvar b = 0; b <= LANES; b++) begin : g_byte
    logic [7:0] v;
    if (b == 0) begin : g_first
      always_comb begin
        case (mode_i)
          FR_LANES: v = (lanes_i != '0) ? drive_i : 8'h00;
          default:  v = pat_byte_i;
        endcase
      end
    end else if (b == LANES) begin : g_last
      always_comb begin
        case (mode_i)
          FR_PAT_LANES: v = (LCNT_W'(b-1) < lanes_i) ? drive_i : 8'h00;
          default:      v = 8'h00;
        endcase
      end
    end else begin : g_mid
      always_comb begin
        case (mode_i)
          FR_PAT_LANES: v = (LCNT_W'(b-1) < lanes_i) ? drive_i : 8'h00;
          FR_LANES:     v = (LCNT_W'(b) < lanes_i) ? drive_i : 8'h00;
          default:      v = 8'h00;
        endcase
      end
    end
    assign wdata_o[8*b +: 8] = v;
  end

  always_comb begin
    case (mode_i)
      FR_PAT_LANES: len_o = LEN_W'(lanes_i) + LEN_W'(1);
      FR_LANES:     len_o = LEN_W'(lanes_i);
      default:      len_o = LEN_W'(1);
    endcase
  end

endmodule

// File: rtl/eq_train_seq.sv
module eq_train_seq
  import eq_train_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int RATE_W   = 16,
  parameter int RATE_P4  = 810,
  parameter int RATE_P3  = 540,
  parameter int MAX_ITER = 5,
  localparam int LCNT_W  = $clog2(LANES+1),
  localparam int LEN_W   = $clog2(LANES+2),
  localparam int STS_W   = 8*LANES+8,
  localparam int DW      = 8*(LANES+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              src_p4_i,
  input  logic              snk_p4_i,
  input  logic              src_p3_i,
  input  logic              snk_p3_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [LCNT_W-1:0] lanes_i,
  input  logic [7:0]        drive_init_i,
  output logic              aux_req_o,
  output logic [1:0]        aux_op_o,
  output logic [LEN_W-1:0]  aux_len_o,
  output logic [DW-1:0]     aux_wdata_o,
  input  logic              aux_ack_i,
  input  logic              aux_ok_i,
  input  logic [STS_W-1:0]  aux_rdata_i,
  output logic              wait_req_o,
  input  logic              wait_done_i,
  output logic              adj_req_o,
  output logic [LANES*4-1:0] adj_bits_o,
  input  logic              adj_done_i,
  input  logic [7:0]        adj_drive_i,
  output logic [2:0]        tx_pat_o,
  output logic              warn_p4_o,
  output logic              warn_p3_o,
  output logic              done_o,
  output logic              pass_o
);

  localparam int IT_W = $clog2(MAX_ITER+1);

  state_e              state_q, state_d;
  pat_e                sel_pat, tx_pat_q;
  logic [7:0]          sel_byte, pat_byte_q, drive_q;
  logic                sel_w4, sel_w3, warn_p4_q, warn_p3_q;
  logic [LCNT_W-1:0]   lanes_q;
  logic [LANES*4-1:0]  adj_q;
  logic [IT_W-1:0]     iter_q;
  logic                pass_q, pass_d;
  logic                cr_ok, eq_ok, last_iter;
  frame_e              fr_mode;
  logic [DW-1:0]       fr_data;
  logic [LEN_W-1:0]    fr_len;

  eq_pat_sel #(
    .RATE_W (RATE_W),
    .RATE_P4(RATE_P4),
    .RATE_P3(RATE_P3)
  ) u_sel (
    .src_p4_i  (src_p4_i),
    .snk_p4_i  (snk_p4_i),
    .src_p3_i  (src_p3_i),
    .snk_p3_i  (snk_p3_i),
    .rate_i    (rate_i),
    .pat_o     (sel_pat),
    .pat_byte_o(sel_byte),
    .warn_p4_o (sel_w4),
    .warn_p3_o (sel_w3)
  );

  eq_lane_eval #(.LANES(LANES), .LCNT_W(LCNT_W)) u_eval (
    .sts_i  (aux_rdata_i[LANES*4-1:0]),
    .align_i(aux_rdata_i[LANES*4]),
    .lanes_i(lanes_q),
    .cr_ok_o(cr_ok),
    .eq_ok_o(eq_ok)
  );

  // status bits the sequencer never looks at
  logic unused_align;
  assign unused_align = ^aux_rdata_i[LANES*4+7:LANES*4+1];

  always_comb begin
    case (state_q)
      S_WR_LANE: fr_mode = FR_LANES;
      S_STOP:    fr_mode = FR_PAT_ONLY;
      default:   fr_mode = FR_PAT_LANES;
    endcase
  end

  eq_frame #(.LANES(LANES), .LCNT_W(LCNT_W), .LEN_W(LEN_W)) u_frame (
    .mode_i    (fr_mode),
    .pat_byte_i((state_q == S_STOP) ? 8'h00 : pat_byte_q),
    .drive_i   (drive_q),
    .lanes_i   (lanes_q),
    .wdata_o   (fr_data),
    .len_o     (fr_len)
  );

  assign last_iter = (iter_q == IT_W'(MAX_ITER-1));

  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_WR_PAT;
          pass_d  = 1'b0;
        end else if (stop_i) begin
          state_d = S_STOP;
        end
      end
      S_WR_PAT:
        if (aux_ack_i) state_d = aux_ok_i ? S_WAIT : S_EXIT;
      S_WAIT:
        if (wait_done_i) state_d = S_RD;
      S_RD: begin
        if (aux_ack_i) begin
          if (!aux_ok_i || !cr_ok) begin
            state_d = S_EXIT;
          end else if (eq_ok) begin
            state_d = S_EXIT;
            pass_d  = 1'b1;
          end else begin
            state_d = S_ADJ;
          end
        end
      end
      S_ADJ:
        if (adj_done_i) state_d = S_WR_LANE;
      S_WR_LANE:
        if (aux_ack_i) state_d = (!aux_ok_i || last_iter) ? S_EXIT : S_WAIT;
      S_EXIT:  state_d = S_IDLE;
      S_STOP:
        if (aux_ack_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      tx_pat_q   <= PAT_IDLE;
      pat_byte_q <= '0;
      drive_q    <= '0;
      lanes_q    <= '0;
      adj_q      <= '0;
      iter_q     <= '0;
      pass_q     <= 1'b0;
      warn_p4_q  <= 1'b0;
      warn_p3_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      if (state_q == S_IDLE && start_i) begin
        tx_pat_q   <= sel_pat;
        pat_byte_q <= sel_byte;
        warn_p4_q  <= sel_w4;
        warn_p3_q  <= sel_w3;
        drive_q    <= drive_init_i;
        lanes_q    <= lanes_i;
        iter_q     <= '0;
      end
      if (state_d == S_EXIT) tx_pat_q <= PAT_IDLE;
      if (state_q == S_RD && aux_ack_i)
        adj_q <= aux_rdata_i[LANES*4+8 +: LANES*4];
      if (state_q == S_ADJ && adj_done_i) drive_q <= adj_drive_i;
      if (state_q == S_WR_LANE && aux_ack_i && !last_iter) iter_q <= iter_q + 1'b1;
    end
  end

  always_comb begin
    case (state_q)
      S_RD:      aux_op_o = AUX_RD;
      S_WR_LANE: aux_op_o = AUX_WR_LANE;
      default:   aux_op_o = AUX_WR_PAT;
    endcase
  end

  assign aux_req_o   = (state_q == S_WR_PAT) || (state_q == S_RD) ||
                       (state_q == S_WR_LANE) || (state_q == S_STOP);
  assign aux_len_o   = (state_q == S_RD) ? LEN_W'(LANES+1) : fr_len;
  assign aux_wdata_o = (state_q == S_RD) ? '0 : fr_data;
  assign wait_req_o  = (state_q == S_WAIT);
  assign adj_req_o   = (state_q == S_ADJ);
  assign adj_bits_o  = adj_q;
  assign tx_pat_o    = tx_pat_q;
  assign warn_p4_o   = warn_p4_q;
  assign warn_p3_o   = warn_p3_q;
  assign done_o      = (state_q == S_EXIT);
  assign pass_o      = pass_q;

endmodule

// File: rtl/eq_train_chk.sv
module eq_train_chk #(
  parameter int MAX_ITER = 5,
  parameter int LEN_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             aux_req_o,
  input logic [1:0]       aux_op_o,
  input logic [LEN_W-1:0] aux_len_o,
  input logic [7:0]       aux_b0,
  input logic             aux_ack_i,
  input logic             wait_req_o,
  input logic             wait_done_i,
  input logic             adj_req_o,
  input logic             done_o,
  input logic [2:0]       tx_pat_o
);

  localparam int CW = $clog2(MAX_ITER+2);

  logic          wait_q;
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q   <= 1'b0;
      wait_cnt <= '0;
    end else begin
      wait_q <= wait_req_o;
      if (done_o)                       wait_cnt <= '0;
      else if (wait_req_o && !wait_q && wait_cnt != '1) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  p_aux_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_req_o && !aux_ack_i |=> aux_req_o && $stable(aux_op_o) && $stable(aux_len_o));

  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req_o && !wait_done_i |=> wait_req_o);

  p_one_req_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({aux_req_o, wait_req_o, adj_req_o}));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_pat_o == 3'd0);

  p_scramble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_req_o && aux_op_o == 2'd1 && aux_b0[3:0] != 4'h0 |->
      aux_b0[5] == (aux_b0[3:0] != 4'h7));

  p_iter_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt <= CW'(MAX_ITER));

  p_adj_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adj_req_o) |-> $past(aux_req_o && aux_ack_i && aux_op_o == 2'd0));

endmodule

bind eq_train_seq eq_train_chk #(.MAX_ITER(MAX_ITER), .LEN_W(LEN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .aux_req_o  (aux_req_o),
  .aux_op_o   (aux_op_o),
  .aux_len_o  (aux_len_o),
  .aux_b0     (aux_wdata_o[7:0]),
  .aux_ack_i  (aux_ack_i),
  .wait_req_o (wait_req_o),
  .wait_done_i(wait_done_i),
  .adj_req_o  (adj_req_o),
  .done_o     (done_o),
  .tx_pat_o   (tx_pat_o)
);

// File: tb/sim_eq_train_seq.sv
`timescale 1ns/1ps
module sim_eq_train_seq;

  localparam int LANES = 4;
  localparam int STS_W = 8*LANES+8;
  localparam int DW    = 8*(LANES+1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic start_i = 0, stop_i = 0;
  logic src_p4_i = 0, snk_p4_i = 0, src_p3_i = 0, snk_p3_i = 0;
  logic [15:0] rate_i = 0;
  logic [2:0]  lanes_i = 0;
  logic [7:0]  drive_init_i = 0;
  logic        aux_req_o;
  logic [1:0]  aux_op_o;
  logic [2:0]  aux_len_o;
  logic [DW-1:0] aux_wdata_o;
  logic        aux_ack_i = 0, aux_ok_i = 1;
  logic [STS_W-1:0] aux_rdata_i = '0;
  logic        wait_req_o, wait_done_i = 0;
  logic        adj_req_o;
  logic [15:0] adj_bits_o;
  logic        adj_done_i = 0;
  logic [7:0]  adj_drive_i = 8'h00;
  logic [2:0]  tx_pat_o;
  logic        warn_p4_o, warn_p3_o, done_o, pass_o;

  eq_train_seq u0 (.*);

  int n_tests = 0, n_fail = 0;

  // scripted responder state
  logic [STS_W-1:0] sts_arr [8];
  int fail_op = -1;
  int rd_n = 0, rd_base = 0;
  int txn_n = 0, wait_n = 0, adj_n = 0;
  logic [1:0]    t_op  [128];
  logic [2:0]    t_len [128];
  logic [DW-1:0] t_dat [128];
  logic [2:0]    t_tx  [128];
  logic [15:0]   adj_last = '0;

  always @(negedge clk_i) begin
    if (aux_ack_i) aux_ack_i = 1'b0;
    else if (aux_req_o) begin
      t_op[txn_n % 128]  = aux_op_o;
      t_len[txn_n % 128] = aux_len_o;
      t_dat[txn_n % 128] = aux_wdata_o;
      t_tx[txn_n % 128]  = tx_pat_o;
      txn_n++;
      aux_ok_i = (fail_op != int'(aux_op_o));
      if (aux_op_o == 2'd0) begin
        aux_rdata_i = sts_arr[(rd_n - rd_base) % 8];
        rd_n++;
      end
      aux_ack_i = 1'b1;
    end
    if (wait_done_i) wait_done_i = 1'b0;
    else if (wait_req_o) begin wait_n++; wait_done_i = 1'b1; end
    if (adj_done_i) adj_done_i = 1'b0;
    else if (adj_req_o) begin adj_n++; adj_last = adj_bits_o; adj_done_i = 1'b1; end
  end

  function automatic logic [STS_W-1:0] mk_sts(input logic [3:0] cr, input logic [3:0] eq,
                                              input logic [3:0] lk, input logic al,
                                              input logic [15:0] adj);
    logic [STS_W-1:0] s;
    s = '0;
    for (int i = 0; i < 4; i++) s[4*i +: 4] = {1'b0, lk[i], eq[i], cr[i]};
    s[16] = al;
    s[39:24] = adj;
    return s;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  int b_txn, b_wait, b_adj;
  logic g_pass, g_w4, g_w3;
  logic [2:0] g_tx;

  task automatic run_seq(input logic s4, k4, s3, k3, input logic [15:0] rate,
                         input logic [2:0] lanes, input logic [7:0] drv);
    int t;
    @(negedge clk_i);
    b_txn = txn_n; b_wait = wait_n; b_adj = adj_n; rd_base = rd_n;
    src_p4_i = s4; snk_p4_i = k4; src_p3_i = s3; snk_p3_i = k3;
    rate_i = rate; lanes_i = lanes; drive_init_i = drv;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 2000) begin @(negedge clk_i); t++; end
    if (t >= 2000) chk("R9 done timeout", 0, 1);
    g_pass = pass_o; g_tx = tx_pat_o; g_w4 = warn_p4_o; g_w3 = warn_p3_o;
    @(negedge clk_i);
    chk("R9 done one cycle", done_o, 0);
    chk("R9 pass held", pass_o, g_pass);
  endtask

  task automatic t_reset;
    chk("R9 reset done", done_o, 0);
    chk("R13 reset no aux", aux_req_o, 0);
    chk("R9 reset tx idle", tx_pat_o, 0);
    chk("R12 reset warn", {warn_p4_o, warn_p3_o}, 0);
  endtask

  // R1 R2 R3 R6: pattern 4, pass first read
  task automatic t_p4_pass;
    fail_op = -1;
    sts_arr[0] = mk_sts(4'hF, 4'hF, 4'hF, 1'b1, 16'h1234);
    run_seq(1, 1, 1, 1, 16'd810, 3'd4, 8'h05);
    chk("R1 p4 byte code", t_dat[b_txn][3:0], 4'h7);
    chk("R2 p4 scramble on", t_dat[b_txn][7:0], 8'h07);
    chk("R3 first write op", t_op[b_txn], 1);
    chk("R3 first write len", t_len[b_txn], 5);
    chk("R3 first write data", t_dat[b_txn], 40'h05_05_05_05_07);
    chk("R1 tx pattern 4", t_tx[b_txn], 4);
    chk("R4 read op", t_op[b_txn+1], 0);
    chk("R4 read len", t_len[b_txn+1], 5);
    chk("R4 one wait", wait_n - b_wait, 1);
    chk("R6 pass", g_pass, 1);
    chk("R9 tx idle at done", g_tx, 0);
    chk("R12 no warn p4", {g_w4, g_w3}, 0);
    chk("R6 no adjust", adj_n - b_adj, 0);
  endtask

  // R1 R2 R7 R12: pattern 3, one adjust, 2 lanes
  task automatic t_p3_adjust;
    fail_op = -1;
    adj_drive_i = 8'h1A;
    sts_arr[0] = mk_sts(4'hF, 4'h0, 4'hF, 1'b1, 16'hA5C3);
    sts_arr[1] = mk_sts(4'h3, 4'h3, 4'h3, 1'b1, 16'h0000);
    run_seq(1, 0, 1, 1, 16'd810, 3'd2, 8'h09);
    chk("R1 R2 p3 byte", t_dat[b_txn], 40'h00_00_09_09_23);
    chk("R3 len two lanes", t_len[b_txn], 3);
    chk("R1 tx pattern 3", t_tx[b_txn], 3);
    chk("R7 adj bits", adj_last, 16'hA5C3);
    chk("R7 adjust count", adj_n - b_adj, 1);
    chk("R7 lane write op", t_op[b_txn+2], 2);
    chk("R7 lane write len", t_len[b_txn+2], 2);
    chk("R7 lane write data", t_dat[b_txn+2], 40'h00_00_00_1A_1A);
    chk("R6 pass after adjust", g_pass, 1);
    chk("R12 warn p4 only", {g_w4, g_w3}, 2'b10);
  endtask

  // R1 R5 R12: pattern 2, one lane, inactive lanes without lock ignored
  task automatic t_p2_one_lane;
    fail_op = -1;
    sts_arr[0] = mk_sts(4'h1, 4'h1, 4'h1, 1'b1, 16'h0);
    run_seq(0, 1, 1, 0, 16'd540, 3'd1, 8'h02);
    chk("R1 R2 p2 byte", t_dat[b_txn], 40'h00_00_00_02_22);
    chk("R1 tx pattern 2", t_tx[b_txn], 2);
    chk("R5 inactive ignored", g_pass, 1);
    chk("R12 warn p3 only", {g_w4, g_w3}, 2'b01);
  endtask

  // R5: lock lost on active lane at second read
  task automatic t_lock_loss;
    fail_op = -1;
    adj_drive_i = 8'h11;
    sts_arr[0] = mk_sts(4'hF, 4'h0, 4'h0, 1'b0, 16'h0);
    sts_arr[1] = mk_sts(4'h7, 4'hF, 4'hF, 1'b1, 16'h0);
    run_seq(0, 0, 0, 0, 16'd270, 3'd4, 8'h00);
    chk("R5 fail", g_pass, 0);
    chk("R5 reads", txn_n - b_txn, 4);
    chk("R5 no adjust on loss", adj_n - b_adj, 1);
    chk("R12 no warn low rate", {g_w4, g_w3}, 0);
  endtask

  // R8: never equalizes
  task automatic t_exhaust;
    fail_op = -1;
    adj_drive_i = 8'h2B;
    for (int i = 0; i < 8; i++) sts_arr[i] = mk_sts(4'hF, 4'h0, 4'hF, 1'b1, 16'h0);
    run_seq(1, 1, 0, 0, 16'd810, 3'd4, 8'h00);
    chk("R8 fail", g_pass, 0);
    chk("R8 waits", wait_n - b_wait, 5);
    chk("R8 adjusts", adj_n - b_adj, 5);
    chk("R8 txns", txn_n - b_txn, 11);
    chk("R8 last is lane write", t_op[b_txn+10], 2);
    chk("R9 tx idle on fail", g_tx, 0);
  endtask

  // R6: alignment missing, then one lane lacks symbol lock
  task automatic t_align_lock;
    fail_op = -1;
    adj_drive_i = 8'h04;
    sts_arr[0] = mk_sts(4'hF, 4'hF, 4'hF, 1'b0, 16'h0);
    sts_arr[1] = mk_sts(4'hF, 4'hF, 4'hB, 1'b1, 16'h0);
    sts_arr[2] = mk_sts(4'hF, 4'hF, 4'hF, 1'b1, 16'h0);
    run_seq(1, 1, 1, 1, 16'd270, 3'd4, 8'h00);
    chk("R6 two adjusts", adj_n - b_adj, 2);
    chk("R6 three waits", wait_n - b_wait, 3);
    chk("R6 final pass", g_pass, 1);
  endtask

  // R10: aux failures
  task automatic t_aux_fail;
    fail_op = 1;
    run_seq(1, 1, 1, 1, 16'd270, 3'd4, 8'h00);
    chk("R10 write fail result", g_pass, 0);
    chk("R10 no wait after fail", wait_n - b_wait, 0);
    fail_op = 0;
    sts_arr[0] = mk_sts(4'hF, 4'hF, 4'hF, 1'b1, 16'h0);
    run_seq(1, 1, 1, 1, 16'd270, 3'd4, 8'h00);
    chk("R10 read fail result", g_pass, 0);
    chk("R10 no adjust", adj_n - b_adj, 0);
    fail_op = -1;
  endtask

  // R11: stop writes one disable byte
  task automatic t_stop;
    int b, seen_done;
    @(negedge clk_i);
    b = txn_n; seen_done = 0;
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk_i); if (done_o) seen_done = 1; end
    chk("R11 one txn", txn_n - b, 1);
    chk("R11 op", t_op[b], 1);
    chk("R11 len", t_len[b], 1);
    chk("R11 byte", t_dat[b][7:0], 8'h00);
    chk("R11 no done", seen_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_p4_pass();
    t_p3_adjust();
    t_p2_one_lane();
    t_lock_loss();
    t_exhaust();
    t_align_lock();
    t_aux_fail();
    t_stop();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule